// File: doc/BRIEF.md
# MSI capability and message generator

This block is the device side of a message-signalled interrupt capability. Software programs it through byte-enabled configuration-space writes and reads. It holds an enable bit, a granted vector count, a message address, a 16-bit message data word and, when the mask variant is built, a per-vector mask register and a pending register. Device logic raises interrupts by presenting a vector number with a one-cycle valid strobe. Each accepted, unmasked request becomes one memory-write request on a valid/ready message port. The request carries a 64-bit address and 32-bit data. The vector number is merged into the low data bits.

A request for a masked vector is not lost. It parks in the pending register. Any later configuration write that touches the capability while the block is enabled releases the parked vectors that are now unmasked, lowest number first. Pending bits beyond the granted count are discarded at that point. While the capability is enabled, an output tells the legacy wire-interrupt logic to stay quiet.

Top module: `msi_cap_gen`

## Requirements
- R1: After reset the control word reads with enable 0 and granted count 0. The capable count and both variant flags keep their build values. Address, data, mask and pending read 0, `msg_valid` is low and `intx_off` is low.
- R2: The capability dword at `CAP_DW` reads id 0x05 in bits 7:0, a zero next pointer in bits 15:8, and control in bits 31:16. The control fields are: enable at bit 16, capable log2 count at 19:17, granted log2 count at 22:20, 64-bit flag at 23 and mask flag at 24. Only enable and the granted field can be written. A granted value above the capable value is stored as the capable value.
- R3: In the 64-bit build, `CAP_DW+1` holds address bits 31:0, `CAP_DW+2` holds address bits 63:32 and `CAP_DW+3` holds the data word in bits 15:0 (bits 31:16 read 0). Address bits 1:0 always read 0. Every message address has bits 1:0 at zero.
- R4: The mask register is at `CAP_DW+4` and the pending register at `CAP_DW+5`. Only mask bits below the capable vector count can be written. The others read 0.
- R5: An accepted request for an unmasked vector produces exactly one message. Its address is the programmed address. Its data bits 31:16 are 0. Its data bits 15:0 are the data word, with the low (granted log2) bits replaced by the vector number.
- R6: A request for a masked vector sets that vector's pending bit and produces no message.
- R7: Requests are ignored while enable is 0. A request whose vector is at or above the granted count is ignored and pulses `irq_err` high for one cycle, in the cycle after the request.
- R8: After a configuration write overlapping the capability, with enable set, two things happen. Pending bits at or above the granted count are cleared. Then each unmasked pending vector is cleared from pending and sent, one per handshake, lowest vector first.
- R9: While `msg_valid` is high and `msg_ready` is low, the message address and data hold steady. Requests that arrive meanwhile are queued and sent afterwards in ascending vector order. A repeat request for a vector already being sent is sent again.
- R10: Writes to the pending register and writes outside the capability's byte range change no register.
- R11: `intx_off` is high exactly while enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration dword address |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr`, combinational |
| irq_valid | input | 1 | Interrupt request strobe |
| irq_vec | input | 5 | Vector number of the request |
| irq_err | output | 1 | Out-of-range request seen |
| msg_valid | output | 1 | Message request valid |
| msg_ready | input | 1 | Message request accepted |
| msg_addr | output | 64 | Message write address |
| msg_data | output | 32 | Message write data |
| intx_off | output | 1 | Legacy wire interrupt must stay deasserted |

## Verification
The bench builds the 64-bit, maskable variant with eight capable vectors and the capability at dword 20. This places the mask and pending registers, the upper address word and the clamp from a written granted value of 7 down to 3 all within reach. Granted counts of 1, 2, 4 and 8 then exercise data merging with zero, one, two and three vector bits. They also show pending bits being discarded when the granted count shrinks. Holding `msg_ready` low while several releases or requests stack up checks message stability and the lowest-first order.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

  localparam int unsigned VEC_MAX = 32;
  localparam int unsigned VEC_W   = 5;
  localparam logic [7:0]  CAP_ID  = 8'h05;

  typedef logic [VEC_MAX-1:0] vec_set_t;

  // Set of vectors below 2**lg.
  function automatic vec_set_t span_of(input logic [2:0] lg);
    vec_set_t r;
    for (int i = 0; i < VEC_MAX; i++) begin
      r[i] = (i < (1 << lg));
    end
    return r;
  endfunction

  // Index of the lowest set bit (0 when empty).
  function automatic logic [VEC_W-1:0] first_set(input vec_set_t s);
    logic [VEC_W-1:0] r;
    r = '0;
    for (int i = VEC_MAX - 1; i >= 0; i--) begin
      if (s[i]) r = VEC_W'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/msi_cfg_regs.sv
module msi_cfg_regs
  import msi_cap_pkg::*;
#(
  parameter int unsigned CAP_LG   = 3,
  parameter bit          ADDR64   = 1'b1,
  parameter bit          MASKABLE = 1'b1,
  parameter int unsigned CAP_DW   = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [5:0]  cfg_addr,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  input  vec_set_t    pend_i,
  output logic [31:0] cfg_rdata,
  output logic        en_o,
  output logic [2:0]  mme_o,
  output logic [63:0] addr_o,
  output logic [15:0] data_o,
  output vec_set_t    mask_o,
  output logic        rel_o
);

  localparam int unsigned OFF_DATA  = ADDR64 ? 3 : 2;
  localparam int unsigned OFF_MASK  = OFF_DATA + 1;
  localparam int unsigned OFF_PEND  = OFF_DATA + 2;
  localparam int unsigned CAP_BYTES = MASKABLE ? (ADDR64 ? 24 : 20) : (ADDR64 ? 14 : 10);
  localparam int unsigned BYTE_LO   = CAP_DW * 4;
  localparam int unsigned BYTE_HI   = BYTE_LO + CAP_BYTES;
  localparam logic [2:0]  CAP_F     = 3'(CAP_LG);
  localparam vec_set_t    MASK_WR   = span_of(CAP_F);

  logic        en_q, en_d;
  logic [2:0]  mme_q, mme_d;
  logic [31:0] alo_q, alo_d;
  logic [31:0] ahi_q, ahi_d;
  logic [15:0] dat_q, dat_d;
  vec_set_t    mask_q, mask_d;
  logic        rel_q;
  logic [3:0]  lane_in;
  logic        hit;
  logic        sel_ctrl, sel_lo, sel_hi, sel_data, sel_mask;

  // byte-range overlap of the write with the capability
  always_comb begin
    for (int i = 0; i < 4; i++) begin
      lane_in[i] = cfg_be[i]
                && (int'({cfg_addr, 2'(i)}) >= int'(BYTE_LO))
                && (int'({cfg_addr, 2'(i)}) <  int'(BYTE_HI));
    end
    hit = cfg_wr && (|lane_in);
  end

  always_comb begin
    sel_ctrl = cfg_wr && (cfg_addr == 6'(CAP_DW));
    sel_lo   = cfg_wr && (cfg_addr == 6'(CAP_DW + 1));
    sel_hi   = ADDR64 && cfg_wr && (cfg_addr == 6'(CAP_DW + 2));
    sel_data = cfg_wr && (cfg_addr == 6'(CAP_DW + OFF_DATA));
    sel_mask = MASKABLE && cfg_wr && (cfg_addr == 6'(CAP_DW + OFF_MASK));
  end

  // next-state
  always_comb begin
    en_d   = en_q;
    mme_d  = mme_q;
    alo_d  = alo_q;
    ahi_d  = ahi_q;
    dat_d  = dat_q;
    mask_d = mask_q;
    if (sel_ctrl && cfg_be[2]) begin
      en_d  = cfg_wdata[16];
      mme_d = (cfg_wdata[22:20] > CAP_F) ? CAP_F : cfg_wdata[22:20];
    end
    for (int i = 0; i < 4; i++) begin
      if (sel_lo && cfg_be[i])   alo_d[8*i +: 8]  = cfg_wdata[8*i +: 8];
      if (sel_hi && cfg_be[i])   ahi_d[8*i +: 8]  = cfg_wdata[8*i +: 8];
      if (sel_mask && cfg_be[i]) mask_d[8*i +: 8] = cfg_wdata[8*i +: 8];
    end
    for (int i = 0; i < 2; i++) begin
      if (sel_data && cfg_be[i]) dat_d[8*i +: 8] = cfg_wdata[8*i +: 8];
    end
    alo_d[1:0] = 2'b00;
    mask_d     = mask_d & MASK_WR;
  end

  // registers, written only on a configuration write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mme_q  <= '0;
      alo_q  <= '0;
      ahi_q  <= '0;
      dat_q  <= '0;
      mask_q <= '0;
      rel_q  <= 1'b0;
    end else begin
      rel_q <= hit;
      if (cfg_wr) begin
        en_q   <= en_d;
        mme_q  <= mme_d;
        alo_q  <= alo_d;
        ahi_q  <= ahi_d;
        dat_q  <= dat_d;
        mask_q <= mask_d;
      end
    end
  end

  // read mux
  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == 6'(CAP_DW)) begin
      cfg_rdata = {7'd0, MASKABLE, ADDR64, mme_q, CAP_F, en_q, 8'h00, CAP_ID};
    end else if (cfg_addr == 6'(CAP_DW + 1)) begin
      cfg_rdata = alo_q;
    end else if (ADDR64 && (cfg_addr == 6'(CAP_DW + 2))) begin
      cfg_rdata = ahi_q;
    end else if (cfg_addr == 6'(CAP_DW + OFF_DATA)) begin
      cfg_rdata = {16'h0000, dat_q};
    end else if (MASKABLE && (cfg_addr == 6'(CAP_DW + OFF_MASK))) begin
      cfg_rdata = mask_q;
    end else if (MASKABLE && (cfg_addr == 6'(CAP_DW + OFF_PEND))) begin
      cfg_rdata = pend_i;
    end
  end

  assign en_o   = en_q;
  assign mme_o  = mme_q;
  assign addr_o = {ahi_q, alo_q};
  assign data_o = dat_q;
  assign mask_o = mask_q;
  assign rel_o  = rel_q;

endmodule

// File: rtl/msi_vec_track.sv
module msi_vec_track
  import msi_cap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [2:0]       mme_i,
  input  vec_set_t         mask_i,
  input  logic             rel_i,
  input  logic             irq_valid,
  input  logic [VEC_W-1:0] irq_vec,
  input  vec_set_t         take_i,
  output vec_set_t         pend_o,
  output vec_set_t         queue_o,
  output logic             err_o
);

  vec_set_t pend_q, pend_d;
  vec_set_t queue_q, queue_d;
  vec_set_t req_set, lim;
  logic     in_range, err_d, err_q;

  always_comb begin
    lim      = span_of(mme_i);
    in_range = lim[irq_vec];
    req_set  = '0;
    if (irq_valid && en_i && in_range) req_set[irq_vec] = 1'b1;
    err_d = irq_valid && en_i && !in_range;

    // masked requests and queued-then-masked vectors park as pending
    pend_d  = pend_q | ((req_set | queue_q) & mask_i);
    queue_d = (queue_q & ~mask_i & ~take_i) | (req_set & ~mask_i);

    if (rel_i && en_i) begin
      pend_d  = pend_d & lim;
      queue_d = queue_d | (pend_d & ~mask_i);
      pend_d  = pend_d & mask_i;
    end
    if (!en_i) queue_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      queue_q <= '0;
      err_q   <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      queue_q <= queue_d;
      err_q   <= err_d;
    end
  end

  assign pend_o  = pend_q;
  assign queue_o = queue_q;
  assign err_o   = err_q;

endmodule

// File: rtl/msi_msg_out.sv
module msi_msg_out
  import msi_cap_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en_i,
  input  vec_set_t    queue_i,
  input  vec_set_t    mask_i,
  input  logic [63:0] addr_i,
  input  logic [15:0] data_i,
  input  logic [2:0]  mme_i,
  input  logic        msg_ready,
  output vec_set_t    take_o,
  output logic        msg_valid,
  output logic [63:0] msg_addr,
  output logic [31:0] msg_data
);

  vec_set_t         cand;
  logic [VEC_W-1:0] pick;
  logic             load;
  logic             valid_d;
  logic [15:0]      low_bits, dsel;

  always_comb begin
    cand     = queue_i & ~mask_i & {VEC_MAX{en_i}};
    pick     = first_set(cand);
    load     = (|cand) && (!msg_valid || msg_ready);
    take_o   = '0;
    if (load) take_o[pick] = 1'b1;
    low_bits = (16'd1 << mme_i) - 16'd1;
    dsel     = (data_i & ~low_bits) | (16'(pick) & low_bits);
    if (load)           valid_d = 1'b1;
    else if (msg_ready) valid_d = 1'b0;
    else                valid_d = msg_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else begin
      msg_valid <= valid_d;
      if (load) begin
        msg_addr <= addr_i;
        msg_data <= {16'h0000, dsel};
      end
    end
  end

endmodule

// File: rtl/msi_cap_gen.sv
module msi_cap_gen
  import msi_cap_pkg::*;
#(
  parameter int unsigned VEC_LOG2 = 3,
  parameter bit          ADDR64   = 1'b1,
  parameter bit          MASKABLE = 1'b1,
  parameter int unsigned CAP_DW   = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [5:0]  cfg_addr,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        irq_valid,
  input  logic [4:0]  irq_vec,
  output logic        irq_err,
  output logic        msg_valid,
  input  logic        msg_ready,
  output logic [63:0] msg_addr,
  output logic [31:0] msg_data,
  output logic        intx_off
);

  logic        en;
  logic [2:0]  mme;
  logic [63:0] addr;
  logic [15:0] data;
  vec_set_t    mask, pend, queue, take;
  logic        rel;

  msi_cfg_regs #(
    .CAP_LG(VEC_LOG2), .ADDR64(ADDR64), .MASKABLE(MASKABLE), .CAP_DW(CAP_DW)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .pend_i(pend), .cfg_rdata(cfg_rdata), .en_o(en),
    .mme_o(mme), .addr_o(addr), .data_o(data), .mask_o(mask), .rel_o(rel)
  );

  msi_vec_track u_track (
    .clk(clk), .rst_n(rst_n), .en_i(en), .mme_i(mme), .mask_i(mask), .rel_i(rel),
    .irq_valid(irq_valid), .irq_vec(irq_vec), .take_i(take), .pend_o(pend),
    .queue_o(queue), .err_o(irq_err)
  );

  msi_msg_out u_out (
    .clk(clk), .rst_n(rst_n), .en_i(en), .queue_i(queue), .mask_i(mask),
    .addr_i(addr), .data_i(data), .mme_i(mme), .msg_ready(msg_ready), .take_o(take),
    .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  assign intx_off = en;

endmodule

// File: rtl/msi_cap_chk.sv
module msi_cap_chk
  import msi_cap_pkg::*;
#(
  parameter int unsigned CAP_LG = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic        en,
  input logic [2:0]  mme,
  input vec_set_t    pend,
  input logic        irq_valid,
  input logic        irq_err,
  input logic        msg_valid,
  input logic        msg_ready,
  input logic [63:0] msg_addr,
  input logic [31:0] msg_data
);

  localparam vec_set_t SPAN = span_of(3'(CAP_LG));

  AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_data) && $stable(msg_addr))); // R9

  AST_DATA_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_data[31:16] == 16'h0000)); // R5

  AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_addr[1:0] == 2'b00)); // R3

  AST_MME_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    mme <= 3'(CAP_LG)); // R2

  AST_PEND_IN_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~SPAN) == '0); // R8

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> $past(irq_valid)); // R7

  AST_SEND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> $past(en)); // R7

endmodule

bind msi_cap_gen msi_cap_chk #(.CAP_LG(VEC_LOG2)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .mme(mme), .pend(pend),
  .irq_valid(irq_valid), .irq_err(irq_err), .msg_valid(msg_valid),
  .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
);

// File: tb/test_msi_cap_gen.sv
`timescale 1ns/1ps
module test_msi_cap_gen;

  localparam int unsigned CDW = 20;
  localparam logic [5:0] D_CTRL = 6'(CDW);
  localparam logic [5:0] D_ALO  = 6'(CDW + 1);
  localparam logic [5:0] D_AHI  = 6'(CDW + 2);
  localparam logic [5:0] D_DATA = 6'(CDW + 3);
  localparam logic [5:0] D_MASK = 6'(CDW + 4);
  localparam logic [5:0] D_PEND = 6'(CDW + 5);
  localparam logic [63:0] EXP_ADDR = 64'h12345678_FFFFFFFC;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr;
  logic [5:0]  cfg_addr;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        irq_valid;
  logic [4:0]  irq_vec;
  logic        irq_err;
  logic        msg_valid;
  logic        msg_ready;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;
  logic        intx_off;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  msi_cap_gen #(.VEC_LOG2(3), .ADDR64(1'b1), .MASKABLE(1'b1), .CAP_DW(CDW)) i_msi_cap_gen (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_valid(irq_valid), .irq_vec(irq_vec),
    .irq_err(irq_err), .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
    .msg_data(msg_data), .intx_off(intx_off)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic read_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] d;
    cfg_read(a, d);
    chk(req, $sformatf("read dw%0d", a), 64'(d), 64'(exp));
  endtask

  task automatic do_irq(input logic [4:0] v);
    @(negedge clk);
    irq_valid = 1'b1; irq_vec = v;
    @(negedge clk);
    irq_valid = 1'b0;
  endtask

  task automatic expect_msg(input string req, input logic [15:0] lo);
    int n = 0;
    while (!msg_valid && n < 10) begin
      @(negedge clk);
      n++;
    end
    chk(req, "msg_valid", 64'(msg_valid), 64'd1);
    chk(req, "msg_data", 64'(msg_data), {48'd0, lo});
    chk(req, "msg_addr", msg_addr, EXP_ADDR);
    if (msg_ready) @(negedge clk);
  endtask

  task automatic expect_quiet(input string req, input int cycles);
    logic seen = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (msg_valid) seen = 1'b1;
    end
    chk(req, "no message", 64'(seen), 64'd0);
  endtask

  task automatic t_reset;
    chk("R1", "msg_valid", 64'(msg_valid), 64'd0);
    chk("R1", "intx_off", 64'(intx_off), 64'd0);
    read_chk("R1", D_CTRL, 32'h0186_0005);
    read_chk("R1", D_ALO, 32'h0);
    read_chk("R1", D_AHI, 32'h0);
    read_chk("R1", D_DATA, 32'h0);
    read_chk("R1", D_MASK, 32'h0);
    read_chk("R1", D_PEND, 32'h0);
  endtask

  task automatic t_ctrl;
    cfg_write(D_CTRL, 4'b1100, 32'hFFFF_0000);      // granted 7 clamps to 3
    read_chk("R2", D_CTRL, 32'h01B7_0005);
    chk("R11", "intx_off on", 64'(intx_off), 64'd1);
    cfg_write(D_CTRL, 4'b0011, 32'h0000_FFFF);      // id and pointer read-only
    read_chk("R2", D_CTRL, 32'h01B7_0005);
    cfg_write(D_CTRL, 4'b1100, 32'h0021_0000);
    read_chk("R2", D_CTRL, 32'h01A7_0005);
  endtask

  task automatic t_addr;
    cfg_write(D_ALO, 4'hF, 32'hFFFF_FFFF);
    read_chk("R3", D_ALO, 32'hFFFF_FFFC);
    cfg_write(D_AHI, 4'hF, 32'h1234_5678);
    read_chk("R3", D_AHI, 32'h1234_5678);
    cfg_write(D_DATA, 4'hF, 32'hABCD_BEEF);
    read_chk("R3", D_DATA, 32'h0000_BEEF);
  endtask

  task automatic t_mask;
    cfg_write(D_MASK, 4'hF, 32'hFFFF_FFFF);
    read_chk("R4", D_MASK, 32'h0000_00FF);
    cfg_write(D_PEND, 4'hF, 32'hFFFF_FFFF);
    read_chk("R10", D_PEND, 32'h0);
    cfg_write(6'(CDW + 6), 4'hF, 32'hFFFF_FFFF);
    read_chk("R10", 6'(CDW + 6), 32'h0);
    cfg_write(6'(CDW - 1), 4'hF, 32'hFFFF_FFFF);
    read_chk("R10", D_CTRL, 32'h01A7_0005);
    read_chk("R10", D_DATA, 32'h0000_BEEF);
    cfg_write(D_MASK, 4'hF, 32'h0);
    expect_quiet("R10", 3);
  endtask

  task automatic t_msg;
    do_irq(5'd2);                                   // granted 4: low 2 bits hold vector
    expect_msg("R5", 16'hBEEE);
    chk("R5", "single message", 64'(msg_valid), 64'd0);
    do_irq(5'd0);
    expect_msg("R5", 16'hBEEC);
    cfg_write(D_CTRL, 4'b1100, 32'h0001_0000);      // one vector: data untouched
    do_irq(5'd0);
    expect_msg("R5", 16'hBEEF);
    cfg_write(D_CTRL, 4'b1100, 32'h0021_0000);
  endtask

  task automatic t_err;
    do_irq(5'd5);
    chk("R7", "irq_err pulse", 64'(irq_err), 64'd1);
    @(negedge clk);
    chk("R7", "irq_err clears", 64'(irq_err), 64'd0);
    expect_quiet("R7", 4);
    cfg_write(D_CTRL, 4'b1100, 32'h0020_0000);      // disable
    chk("R11", "intx_off off", 64'(intx_off), 64'd0);
    do_irq(5'd1);
    chk("R7", "no error while off", 64'(irq_err), 64'd0);
    expect_quiet("R7", 4);
    cfg_write(D_CTRL, 4'b1100, 32'h0021_0000);
  endtask

  task automatic t_masked;
    cfg_write(D_MASK, 4'hF, 32'h0000_000A);
    do_irq(5'd1);
    do_irq(5'd3);
    expect_quiet("R6", 3);
    read_chk("R6", D_PEND, 32'h0000_000A);
    msg_ready = 1'b0;
    cfg_write(D_MASK, 4'hF, 32'h0);                 // release, vector 1 first
    expect_msg("R8", 16'hBEED);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9", "held valid", 64'(msg_valid), 64'd1);
      chk("R9", "held data", 64'(msg_data), 64'h0000_BEED);
    end
    msg_ready = 1'b1;
    expect_msg("R8", 16'hBEED);
    expect_msg("R8", 16'hBEEF);
    read_chk("R8", D_PEND, 32'h0);
  endtask

  task automatic t_clear;
    cfg_write(D_MASK, 4'hF, 32'h0000_00FF);
    cfg_write(D_CTRL, 4'b1100, 32'h0031_0000);      // granted 8
    do_irq(5'd0);
    do_irq(5'd6);
    read_chk("R6", D_PEND, 32'h0000_0041);
    cfg_write(D_CTRL, 4'b1100, 32'h0011_0000);      // granted 2: vector 6 dropped
    @(negedge clk);
    read_chk("R8", D_PEND, 32'h0000_0001);
    expect_quiet("R8", 3);
    cfg_write(D_MASK, 4'hF, 32'h0);
    expect_msg("R8", 16'hBEEE);
    read_chk("R8", D_PEND, 32'h0);
  endtask

  task automatic t_busy;
    cfg_write(D_CTRL, 4'b1100, 32'h0031_0000);
    msg_ready = 1'b0;
    @(negedge clk);
    irq_valid = 1'b1; irq_vec = 5'd0;
    @(negedge clk);
    irq_vec = 5'd1;
    @(negedge clk);
    irq_vec = 5'd0;
    @(negedge clk);
    irq_valid = 1'b0;
    chk("R9", "busy valid", 64'(msg_valid), 64'd1);
    chk("R9", "busy data", 64'(msg_data), 64'h0000_BEE8);
    @(negedge clk);
    chk("R9", "busy held", 64'(msg_data), 64'h0000_BEE8);
    msg_ready = 1'b1;
    expect_msg("R9", 16'hBEE8);
    expect_msg("R9", 16'hBEE8);
    expect_msg("R9", 16'hBEE9);
    expect_quiet("R9", 3);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_addr = '0; cfg_be = '0; cfg_wdata = '0;
    irq_valid = 1'b0; irq_vec = '0; msg_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_addr();
    t_mask();
    t_msg();
    t_err();
    t_masked();
    t_clear();
    t_busy();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule